// File: doc/BRIEF.md
# Packet-Atomic Five-Way Stream Merger

This block merges five AXI4-Stream inputs into one AXI4-Stream output. All six streams have the same data, keep and user widths. The inputs are assumed to be buffered upstream, so the block needs no width conversion and no storage. It hands the output to one input for a whole packet. Beats of different packets are never interleaved on the output. Among inputs with a packet waiting, the choice is round-robin.

An AXI4-Lite slave sits beside the datapath. Through it, software can read:
- an identification word and a revision word, both set by parameters;
- two free-running 32-bit packet counters, one on the input side and one on the output side;
- two test words: one that reads back the negation of what was written, and one that reads back what was written plus a parameter offset.

The counters wrap on overflow and clear on reset.

Top module: `pkt_merge_arb`

## Requirements
- R1: After the synchronous active-low reset: `m_tvalid` and every `s_tready` bit are 0, no AXI4-Lite response is pending, and both packet counters read 0.
- R2: Once a packet's first beat is on the output, every following output beat comes from the same input until the beat with `m_tlast` set. `m_tlast` is set exactly on each packet's final beat.
- R3: At most one `s_tready` bit is high, and only the granted input's bit follows `m_tready`. While `m_tvalid` is high, `s_tready` equals `m_tready` shifted to the granted input's position.
- R4: A new grant goes to the first input with `s_tvalid` high, searching upward cyclically from the input after the last one granted. After reset the search starts at input 0.
- R5: `m_tdata`, `m_tkeep`, `m_tuser` and `m_tlast` equal the granted input's fields. While `m_tvalid` is high and `m_tready` is low, the output beat stays unchanged into the next cycle.
- R6: Byte address 0x00 reads the parameter `ID_VAL` and 0x04 reads `REV_VAL`. Writes to these two addresses leave them unchanged.
- R7: Byte address 0x08 reads the two's-complement negation of the last value written there.
- R8: Byte address 0x14 reads the last value written there plus the parameter `ECHO_OFS`, modulo 2^32.
- R9: Byte address 0x0C reads the count of input handshakes with `s_tlast` set, on any input. Writes to it are ignored.
- R10: Byte address 0x10 reads the count of output handshakes with `m_tlast` set. Writes to it are ignored.
- R11: Every write and read response is OKAY (`2'b00`). A response stays valid and unchanged until it is accepted. A read of any other address, including a misaligned one, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | N_IN*DATA_W | Input beat data, one slice per input |
| s_tkeep | input | N_IN*DATA_W/8 | Input byte enables per input |
| s_tuser | input | N_IN*USER_W | Input side-band per input |
| s_tlast | input | N_IN | Final beat of packet, per input |
| s_tvalid | input | N_IN | Beat present, per input |
| s_tready | output | N_IN | Beat accepted, per input |
| m_tdata | output | DATA_W | Merged beat data |
| m_tkeep | output | DATA_W/8 | Merged byte enables |
| m_tuser | output | USER_W | Merged side-band |
| m_tlast | output | 1 | Final beat of merged packet |
| m_tvalid | output | 1 | Merged beat present |
| m_tready | input | 1 | Downstream accepts the beat |
| lite_awaddr | input | ADDR_W | Write address |
| lite_awvalid | input | 1 | Write address valid |
| lite_awready | output | 1 | Write address accepted |
| lite_wdata | input | 32 | Write data |
| lite_wvalid | input | 1 | Write data valid |
| lite_wready | output | 1 | Write data accepted |
| lite_bresp | output | 2 | Write response |
| lite_bvalid | output | 1 | Write response valid |
| lite_bready | input | 1 | Write response accepted |
| lite_araddr | input | ADDR_W | Read address |
| lite_arvalid | input | 1 | Read address valid |
| lite_arready | output | 1 | Read address accepted |
| lite_rdata | output | 32 | Read data |
| lite_rresp | output | 2 | Read response |
| lite_rvalid | output | 1 | Read data valid |
| lite_rready | input | 1 | Read data accepted |

## Verification
The merge is first driven in a directed burst. All five inputs raise a packet together while the output is stalled, which separates a true round-robin start at input 0 from a fixed-priority or stale pointer. It also exercises holding the output under backpressure. After that, randomly gapped inputs with packet lengths from one to five beats, against random output backpressure, show whether a grant is released exactly on `m_tlast`. This catches interleaving, early release and lost beats. The random phase also checks the search order when only some inputs are waiting. Register traffic around the stream phase checks counters against the number of packets sent, and checks the test words at zero, sign-bit and wrap values.

// File: rtl/pkt_merge_pkg.sv
// Package: shared constants and register selector for the stream merger.
package pkt_merge_pkg;
    localparam int unsigned LITE_DATA_W = 32;
    localparam logic [1:0]  RESP_OKAY   = 2'b00;

    // Word index within the register window (byte address bits [4:2]).
    typedef enum logic [2:0] {
        REG_IDENT = 3'd0,
        REG_REV   = 3'd1,
        REG_NEG   = 3'd2,
        REG_RXPKT = 3'd3,
        REG_TXPKT = 3'd4,
        REG_ECHO  = 3'd5
    } reg_sel_e;

    localparam logic [2:0] REG_LAST = 3'd5;
endpackage

// File: rtl/pkt_rr_grant.sv
// Round-robin packet grant.
// Picks a requester cyclically after the previously granted one and locks
// that choice from the first visible beat until the final beat is accepted.
// Assumes requesters keep tvalid high until accepted.
module pkt_rr_grant #(
    parameter int unsigned N_IN  = 5,
    parameter int unsigned IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  req,
    input  logic             out_fire,
    input  logic             out_last,
    output logic [N_IN-1:0]  gnt_oh,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             gnt_valid
);
    logic             locked_q;
    logic [IDX_W-1:0] lock_idx_q;
    logic [IDX_W-1:0] prev_idx_q;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;

    // Search cyclically starting one above the previous grant.
    always_comb begin
        pick_found = 1'b0;
        pick_idx   = '0;
        for (int k = 1; k <= int'(N_IN); k++) begin
            int cand;
            cand = (int'(prev_idx_q) + k) % int'(N_IN);
            if (!pick_found && req[cand]) begin
                pick_found = 1'b1;
                pick_idx   = IDX_W'(cand);
            end
        end
    end

    // Present the locked grant, or the fresh pick while idle.
    always_comb begin
        gnt_idx   = locked_q ? lock_idx_q : pick_idx;
        gnt_valid = locked_q | pick_found;
        gnt_oh    = '0;
        if (gnt_valid) gnt_oh[gnt_idx] = 1'b1;
    end

    // Lock on a fresh pick and release on the accepted final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q   <= 1'b0;
            lock_idx_q <= '0;
            prev_idx_q <= IDX_W'(N_IN - 1);
        end else if (!locked_q) begin
            if (pick_found) begin
                lock_idx_q <= pick_idx;
                prev_idx_q <= pick_idx;
                locked_q   <= !(out_fire && out_last);
            end
        end else if (out_fire && out_last) begin
            locked_q <= 1'b0;
        end
    end

    // The grant must not move before the final beat of the packet leaves.
    assert_grant_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !(out_fire && out_last)) |=> (gnt_valid && $stable(gnt_idx)));
endmodule

// File: rtl/pkt_beat_mux.sv
// Beat multiplexer.
// Steers the granted input's beat fields onto the single output.
// Assumes sel_idx is below N_IN whenever sel_valid is high.
module pkt_beat_mux #(
    parameter int unsigned N_IN   = 5,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned USER_W = 32,
    parameter int unsigned KEEP_W = DATA_W / 8,
    parameter int unsigned IDX_W  = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic [N_IN-1:0][DATA_W-1:0] in_data,
    input  logic [N_IN-1:0][KEEP_W-1:0] in_keep,
    input  logic [N_IN-1:0][USER_W-1:0] in_user,
    input  logic [N_IN-1:0]             in_last,
    input  logic [N_IN-1:0]             in_valid,
    input  logic [IDX_W-1:0]            sel_idx,
    input  logic                        sel_valid,
    output logic [DATA_W-1:0]           out_data,
    output logic [KEEP_W-1:0]           out_keep,
    output logic [USER_W-1:0]           out_user,
    output logic                        out_last,
    output logic                        out_valid
);
    // Select one slice of each field by the grant index.
    always_comb begin
        out_data  = '0;
        out_keep  = '0;
        out_user  = '0;
        out_last  = 1'b0;
        out_valid = 1'b0;
        for (int i = 0; i < int'(N_IN); i++) begin
            if (sel_valid && (int'(sel_idx) == i)) begin
                out_data  = in_data[i];
                out_keep  = in_keep[i];
                out_user  = in_user[i];
                out_last  = in_last[i];
                out_valid = in_valid[i];
            end
        end
    end
endmodule

// File: rtl/pkt_lite_regs.sv
// Register window on an AXI4-Lite slave.
// Holds identification, two packet counters and two test words.
// One write and one read may be outstanding. Every response is OKAY.
// Assumes full-word writes: byte strobes are not offered.
module pkt_lite_regs
    import pkt_merge_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [31:0] ID_VAL   = 32'h0000_DA01,
    parameter logic [31:0] REV_VAL  = 32'h0001_0000,
    parameter logic [31:0] ECHO_OFS = 32'h0000_1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_evt,
    input  logic                   tx_evt,
    input  logic [ADDR_W-1:0]      awaddr,
    input  logic                   awvalid,
    output logic                   awready,
    input  logic [LITE_DATA_W-1:0] wdata,
    input  logic                   wvalid,
    output logic                   wready,
    output logic [1:0]             bresp,
    output logic                   bvalid,
    input  logic                   bready,
    input  logic [ADDR_W-1:0]      araddr,
    input  logic                   arvalid,
    output logic                   arready,
    output logic [LITE_DATA_W-1:0] rdata,
    output logic [1:0]             rresp,
    output logic                   rvalid,
    input  logic                   rready
);
    logic [LITE_DATA_W-1:0] rx_cnt_q, tx_cnt_q, neg_q, echo_q, rd_word;
    logic                   wr_go, rd_go, wr_hit, rd_hit;

    // True when an address is aligned and falls on a defined word.
    function automatic logic addr_hit(input logic [ADDR_W-1:0] a);
        return (a[ADDR_W-1:5] == '0) && (a[1:0] == 2'b00) && (a[4:2] <= REG_LAST);
    endfunction

    assign wr_go   = awvalid && wvalid && !bvalid;
    assign awready = wr_go;
    assign wready  = wr_go;
    assign rd_go   = arvalid && !rvalid;
    assign arready = rd_go;
    assign bresp   = RESP_OKAY;
    assign rresp   = RESP_OKAY;
    assign wr_hit  = addr_hit(awaddr);
    assign rd_hit  = addr_hit(araddr);

    // Count packets seen entering and leaving. Wraps modulo 2^32.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_cnt_q <= '0;
            tx_cnt_q <= '0;
        end else begin
            rx_cnt_q <= rx_cnt_q + LITE_DATA_W'(rx_evt);
            tx_cnt_q <= tx_cnt_q + LITE_DATA_W'(tx_evt);
        end
    end

    // Accept a write into a test word and raise the write response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q  <= '0;
            echo_q <= '0;
            bvalid <= 1'b0;
        end else begin
            if (bvalid && bready) bvalid <= 1'b0;
            if (wr_go) begin
                bvalid <= 1'b1;
                if (wr_hit) begin
                    case (reg_sel_e'(awaddr[4:2]))
                        REG_NEG:  neg_q  <= wdata;
                        REG_ECHO: echo_q <= wdata;
                        default:  ;
                    endcase
                end
            end
        end
    end

    // Form the value of the addressed word.
    always_comb begin
        rd_word = '0;
        if (rd_hit) begin
            case (reg_sel_e'(araddr[4:2]))
                REG_IDENT: rd_word = ID_VAL;
                REG_REV:   rd_word = REV_VAL;
                REG_NEG:   rd_word = ~neg_q + 1'b1;
                REG_RXPKT: rd_word = rx_cnt_q;
                REG_TXPKT: rd_word = tx_cnt_q;
                REG_ECHO:  rd_word = echo_q + ECHO_OFS;
                default:   rd_word = '0;
            endcase
        end
    end

    // Capture read data and hold it until accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (rd_go) begin
            rvalid <= 1'b1;
            rdata  <= rd_word;
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end

    assert_rx_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_evt |=> $stable(rx_cnt_q));
    assert_tx_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_evt |=> $stable(tx_cnt_q));
    assert_bresp_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);
    assert_rdata_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));
endmodule

// File: rtl/pkt_merge_arb.sv
// Five-way packet-atomic stream merger with a register window.
// Grants the output to one input per packet, round-robin, and counts
// packets on both sides. Inputs are assumed buffered upstream and
// AXI4-Stream compliant (tvalid held until accepted).
module pkt_merge_arb
    import pkt_merge_pkg::*;
#(
    parameter int unsigned N_IN     = 5,
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned USER_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter logic [31:0] ID_VAL   = 32'h0000_DA01,
    parameter logic [31:0] REV_VAL  = 32'h0001_0000,
    parameter logic [31:0] ECHO_OFS = 32'h0000_1000,
    parameter int unsigned KEEP_W   = DATA_W / 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_IN-1:0][DATA_W-1:0] s_tdata,
    input  logic [N_IN-1:0][KEEP_W-1:0] s_tkeep,
    input  logic [N_IN-1:0][USER_W-1:0] s_tuser,
    input  logic [N_IN-1:0]             s_tlast,
    input  logic [N_IN-1:0]             s_tvalid,
    output logic [N_IN-1:0]             s_tready,
    output logic [DATA_W-1:0]           m_tdata,
    output logic [KEEP_W-1:0]           m_tkeep,
    output logic [USER_W-1:0]           m_tuser,
    output logic                        m_tlast,
    output logic                        m_tvalid,
    input  logic                        m_tready,
    input  logic [ADDR_W-1:0]           lite_awaddr,
    input  logic                        lite_awvalid,
    output logic                        lite_awready,
    input  logic [31:0]                 lite_wdata,
    input  logic                        lite_wvalid,
    output logic                        lite_wready,
    output logic [1:0]                  lite_bresp,
    output logic                        lite_bvalid,
    input  logic                        lite_bready,
    input  logic [ADDR_W-1:0]           lite_araddr,
    input  logic                        lite_arvalid,
    output logic                        lite_arready,
    output logic [31:0]                 lite_rdata,
    output logic [1:0]                  lite_rresp,
    output logic                        lite_rvalid,
    input  logic                        lite_rready
);
    localparam int unsigned IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;

    logic [N_IN-1:0]  gnt_oh;
    logic [IDX_W-1:0] gnt_idx;
    logic             gnt_valid;
    logic             m_fire, rx_evt, tx_evt;

    assign m_fire   = m_tvalid && m_tready;
    assign s_tready = gnt_oh & {N_IN{m_tready}};
    assign rx_evt   = |(s_tvalid & s_tready & s_tlast);
    assign tx_evt   = m_fire && m_tlast;

    pkt_rr_grant #(.N_IN(N_IN), .IDX_W(IDX_W)) u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (s_tvalid),
        .out_fire  (m_fire),
        .out_last  (m_tlast),
        .gnt_oh    (gnt_oh),
        .gnt_idx   (gnt_idx),
        .gnt_valid (gnt_valid)
    );

    pkt_beat_mux #(
        .N_IN(N_IN), .DATA_W(DATA_W), .USER_W(USER_W), .KEEP_W(KEEP_W), .IDX_W(IDX_W)
    ) u_mux (
        .in_data   (s_tdata),
        .in_keep   (s_tkeep),
        .in_user   (s_tuser),
        .in_last   (s_tlast),
        .in_valid  (s_tvalid),
        .sel_idx   (gnt_idx),
        .sel_valid (gnt_valid),
        .out_data  (m_tdata),
        .out_keep  (m_tkeep),
        .out_user  (m_tuser),
        .out_last  (m_tlast),
        .out_valid (m_tvalid)
    );

    pkt_lite_regs #(
        .ADDR_W(ADDR_W), .ID_VAL(ID_VAL), .REV_VAL(REV_VAL), .ECHO_OFS(ECHO_OFS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_evt  (rx_evt),
        .tx_evt  (tx_evt),
        .awaddr  (lite_awaddr),
        .awvalid (lite_awvalid),
        .awready (lite_awready),
        .wdata   (lite_wdata),
        .wvalid  (lite_wvalid),
        .wready  (lite_wready),
        .bresp   (lite_bresp),
        .bvalid  (lite_bvalid),
        .bready  (lite_bready),
        .araddr  (lite_araddr),
        .arvalid (lite_arvalid),
        .arready (lite_arready),
        .rdata   (lite_rdata),
        .rresp   (lite_rresp),
        .rvalid  (lite_rvalid),
        .rready  (lite_rready)
    );

    assert_single_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_tready));
    assert_ready_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|s_tready) |-> m_tready);
    assert_beat_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
    assert_no_interleave_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_fire && !m_tlast) |=> $stable(gnt_oh));
endmodule

// File: tb/pkt_merge_arb_bench.sv
// Bench for the five-way merger. Stimulus is seeded random with directed
// corners, and expected values come from bench functions.
module pkt_merge_arb_bench;
    localparam int CLK_P  = 8;
    localparam int N_IN   = 5;
    localparam int DATA_W = 64;
    localparam int USER_W = 32;
    localparam int KEEP_W = DATA_W / 8;
    localparam int ADDR_W = 8;
    localparam int PKTS   = 20;
    localparam int TOTAL  = N_IN * PKTS;
    localparam logic [31:0] ID_V  = 32'h0000_DA01;
    localparam logic [31:0] REV_V = 32'h0001_0000;
    localparam logic [31:0] OFS_V = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_IN-1:0][DATA_W-1:0] s_tdata = '0;
    logic [N_IN-1:0][KEEP_W-1:0] s_tkeep = '0;
    logic [N_IN-1:0][USER_W-1:0] s_tuser = '0;
    logic [N_IN-1:0] s_tlast = '0, s_tvalid = '0, s_tready;
    logic [DATA_W-1:0] m_tdata;
    logic [KEEP_W-1:0] m_tkeep;
    logic [USER_W-1:0] m_tuser;
    logic m_tlast, m_tvalid, m_tready = 1'b0;
    logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
    logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0] wdata = '0, rdata;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0] bresp, rresp;

    int n_chk = 0, n_fail = 0, out_pkts = 0;
    bit go = 0, ended = 0;

    always #(CLK_P/2) clk = ~clk;

    pkt_merge_arb #(.N_IN(N_IN), .DATA_W(DATA_W), .USER_W(USER_W), .ADDR_W(ADDR_W),
                    .ID_VAL(ID_V), .REV_VAL(REV_V), .ECHO_OFS(OFS_V)) u_pkt_merge_arb (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tuser(s_tuser), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tuser(m_tuser), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready),
        .lite_awaddr(awaddr), .lite_awvalid(awvalid), .lite_awready(awready),
        .lite_wdata(wdata), .lite_wvalid(wvalid), .lite_wready(wready),
        .lite_bresp(bresp), .lite_bvalid(bvalid), .lite_bready(bready),
        .lite_araddr(araddr), .lite_arvalid(arvalid), .lite_arready(arready),
        .lite_rdata(rdata), .lite_rresp(rresp), .lite_rvalid(rvalid), .lite_rready(rready)
    );

    // Packet shape and contents, shared by drivers and monitor.
    function automatic int pkt_len(int src, int p);
        return 1 + ((src * 3 + p * 7) % 5);
    endfunction
    function automatic logic [DATA_W-1:0] beat_data(int src, int p, int b);
        return {8'(src), 8'(p), 8'(b), 40'h5A_5A5A_5A5A ^ 40'(p * 131 + b * 17 + src)};
    endfunction
    function automatic logic [KEEP_W-1:0] beat_keep(int src, int p, int b);
        return (b == pkt_len(src, p) - 1) ? (8'hFF >> ((src + p) % 8)) : 8'hFF;
    endfunction
    function automatic logic [USER_W-1:0] beat_user(int src, int p, int b);
        return {8'(src), 8'(p), 16'(b) ^ 16'h3C00};
    endfunction
    function automatic int rr_expect(int last, logic [N_IN-1:0] v);
        for (int k = 1; k <= N_IN; k++) begin
            if (v[(last + k) % N_IN]) return (last + k) % N_IN;
        end
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic lite_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, output logic [1:0] r);
        bit ok;
        @(negedge clk);
        awaddr = a; wdata = d; awvalid = 1; wvalid = 1; bready = 1;
        do begin #(CLK_P/4); ok = awready; @(negedge clk); end while (!ok);
        awvalid = 0; wvalid = 0;
        while (!bvalid) @(negedge clk);
        r = bresp;
        @(negedge clk);
        bready = 0;
    endtask

    task automatic lite_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic [1:0] r);
        bit ok;
        @(negedge clk);
        araddr = a; arvalid = 1; rready = 1;
        do begin #(CLK_P/4); ok = arready; @(negedge clk); end while (!ok);
        arvalid = 0;
        while (!rvalid) @(negedge clk);
        d = rdata; r = rresp;
        @(negedge clk);
        rready = 0;
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d; logic [1:0] r;
        lite_rd(a, d, r);
        chk(d == exp, req, "read data", 64'(d), 64'(exp));
        chk(r == 2'b00, "R11", "read resp", 64'(r), 64'd0);
    endtask

    task automatic wr_chk(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        logic [1:0] r;
        lite_wr(a, d, r);
        chk(r == 2'b00, "R11", "write resp", 64'(r), 64'd0);
    endtask

    // One driver per input: sends PKTS packets with random gaps.
    for (genvar gi = 0; gi < N_IN; gi++) begin : g_drv
        initial begin
            wait (go);
            @(negedge clk);
            for (int p = 0; p < PKTS; p++) begin
                for (int b = 0; b < pkt_len(gi, p); b++) begin
                    bit took;
                    s_tdata[gi]  = beat_data(gi, p, b);
                    s_tkeep[gi]  = beat_keep(gi, p, b);
                    s_tuser[gi]  = beat_user(gi, p, b);
                    s_tlast[gi]  = (b == pkt_len(gi, p) - 1);
                    s_tvalid[gi] = 1'b1;
                    do begin #(CLK_P/4); took = s_tready[gi]; @(negedge clk); end while (!took);
                    if (($urandom % 5) == 0) begin
                        s_tvalid[gi] = 1'b0;
                        repeat (1 + $urandom % 3) @(negedge clk);
                    end
                end
                s_tvalid[gi] = 1'b0;
                repeat ($urandom % 6) @(negedge clk);
            end
            s_tvalid[gi] = 1'b0;
        end
    end

    // Output backpressure: stalled for the directed burst, then random.
    initial begin
        wait (go);
        repeat (8) @(negedge clk);
        forever begin
            @(negedge clk);
            m_tready = ($urandom % 4) != 0;
        end
    end

    // Monitor: grant order, ready steering, beat contents and hold.
    initial begin
        int last = N_IN - 1, cur = 0, beat = 0;
        int exp_pkt [N_IN];
        bit in_pkt = 0, chosen = 0, stalled = 0;
        logic [DATA_W-1:0] held;
        for (int i = 0; i < N_IN; i++) exp_pkt[i] = 0;
        wait (go);
        while (out_pkts < TOTAL) begin
            @(negedge clk);
            #(CLK_P/4);
            if (stalled)
                chk(m_tvalid && (m_tdata == held), "R5", "beat held under stall",
                    64'(m_tdata), 64'(held));
            if (!in_pkt && !chosen && m_tvalid) begin
                int e;
                e = rr_expect(last, s_tvalid);
                chk(int'(m_tuser[31:24]) == e, "R4", "granted input",
                    64'(m_tuser[31:24]), 64'(e));
                cur = int'(m_tuser[31:24]);
                chosen = 1;
            end
            if (m_tvalid) begin
                logic [N_IN-1:0] er;
                er = m_tready ? (N_IN'(1) << cur) : '0;
                chk(s_tready == er, "R3", "input ready vector", 64'(s_tready), 64'(er));
            end
            stalled = m_tvalid && !m_tready;
            held = m_tdata;
            if (m_tvalid && m_tready) begin
                int p, n;
                p = exp_pkt[cur];
                n = pkt_len(cur, p);
                chk(int'(m_tuser[31:24]) == cur, "R2", "beat source",
                    64'(m_tuser[31:24]), 64'(cur));
                chk(m_tdata == beat_data(cur, p, beat), "R5", "tdata",
                    64'(m_tdata), 64'(beat_data(cur, p, beat)));
                chk(m_tuser == beat_user(cur, p, beat), "R5", "tuser",
                    64'(m_tuser), 64'(beat_user(cur, p, beat)));
                chk(m_tkeep == beat_keep(cur, p, beat), "R5", "tkeep",
                    64'(m_tkeep), 64'(beat_keep(cur, p, beat)));
                chk(m_tlast == (beat == n - 1), "R2", "tlast position",
                    64'(m_tlast), 64'(beat == n - 1));
                if (m_tlast) begin
                    exp_pkt[cur]++;
                    beat = 0; in_pkt = 0; chosen = 0; last = cur;
                    out_pkts++;
                end else begin
                    beat++; in_pkt = 1;
                end
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d packets expected %0d", out_pkts, TOTAL);
        finish_run();
    end

    // Main sequence.
    initial begin
        void'($urandom(32'd20417));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #(CLK_P/4);
        chk(!m_tvalid, "R1", "m_tvalid after reset", 64'(m_tvalid), 64'd0);
        chk(s_tready == '0, "R1", "s_tready after reset", 64'(s_tready), 64'd0);
        chk(!bvalid && !rvalid, "R1", "lite responses after reset", 64'({bvalid, rvalid}), 64'd0);
        rd_chk(8'h0C, 32'd0, "R1");
        rd_chk(8'h10, 32'd0, "R1");
        rd_chk(8'h00, ID_V, "R6");
        rd_chk(8'h04, REV_V, "R6");
        // Writes to read-only words are ignored (R6, R9, R10).
        wr_chk(8'h00, 32'h1234_5678);
        wr_chk(8'h04, 32'hFFFF_FFFF);
        wr_chk(8'h0C, 32'h0000_0077);
        wr_chk(8'h10, 32'h0000_0099);
        rd_chk(8'h00, ID_V, "R6");
        rd_chk(8'h04, REV_V, "R6");
        rd_chk(8'h0C, 32'd0, "R9");
        rd_chk(8'h10, 32'd0, "R10");
        // Negation test word at 1, 0 and the sign bit (R7).
        wr_chk(8'h08, 32'd1);
        rd_chk(8'h08, 32'hFFFF_FFFF, "R7");
        wr_chk(8'h08, 32'd0);
        rd_chk(8'h08, 32'd0, "R7");
        wr_chk(8'h08, 32'h8000_0000);
        rd_chk(8'h08, 32'h8000_0000, "R7");
        // Offset echo, including wrap past 2^32 (R8).
        wr_chk(8'h14, 32'h0000_0005);
        rd_chk(8'h14, 32'h0000_1005, "R8");
        wr_chk(8'h14, 32'hFFFF_FFFF);
        rd_chk(8'h14, 32'h0000_0FFF, "R8");
        // Unmapped and misaligned addresses read zero (R11).
        rd_chk(8'h18, 32'd0, "R11");
        rd_chk(8'h09, 32'd0, "R11");
        go = 1;
        wait (out_pkts == TOTAL);
        repeat (4) @(negedge clk);
        rd_chk(8'h0C, 32'(TOTAL), "R9");
        rd_chk(8'h10, 32'(TOTAL), "R10");
        rd_chk(8'h08, 32'h8000_0000, "R7");
        finish_run();
    end
endmodule